// File: doc/BRIEF.md
# Quadrature Position Timer with Configuration Lock

This block turns the two phase signals of an incremental encoder into a 16-bit position held in a counter. Each phase input passes through a two-flop synchroniser. A decoder state machine then compares every new sample of the phase pair with the one before it. Each legal edge on either phase moves the position by one step, which gives four steps per full encoder cycle. Up steps wrap from the limit value back to the start value, and down steps wrap from the start value to the limit value. A power-of-two prescaler sets how often the decoder takes a sample of the phases.

Software uses a simple single-cycle 32-bit register bus with word addresses. A two-state lock machine protects the configuration. While it is shut, writes to control, mode, start, limit and quadrature-control registers are dropped. A write to the count register never stores its data. It reloads the position from the start value instead.

The lock machine has the states LK_OPEN (reset) and LK_SHUT. It moves LK_OPEN to LK_SHUT on a write of 1 to the lock bit, and LK_SHUT to LK_OPEN on a write of 1 to the unlock bit of the mode register. The decoder machine has the states QP_00, QP_01, QP_10 and QP_11, named after the last sampled {A,B} pair. On each sample tick it moves to the state of the new pair. The moves 00→10→11→01→00 are up steps. The reverse moves are down steps. A move that changes both bits is illegal.

Top module: `quad_pos_timer`

## Requirements
- R1: After reset every register reads 0 and the lock is open. The addresses are 0 control, 1 count, 2 start, 3 limit, 4 mode, 5 protect, 6 quadrature control.
- R2: With counting enabled, each single-bit change of the sampled {A,B} pair moves the count by one. The order 00→10→11→01→00 counts up, and the reverse order counts down.
- R3: A sample in which both phases changed leaves the count unchanged, and the decoder still takes the new pair as its reference.
- R4: An up step while the count equals the limit (address 3) loads the start value.
- R5: A down step while the count equals the start value (address 2) loads the limit value.
- R6: Any write to the count register loads the start value, whatever the written data.
- R7: Control bits [2:0] select a sample interval of 2^n clock cycles. Writing control clears the divider, so the first sample falls on the 2^n-th clock after the write.
- R8: Writing 1 to protect bit 0 shuts the lock, and protect bit 0 reads back 1. While the lock is shut, writes to control, mode, start, limit and quadrature control are ignored.
- R9: Writing mode with bit 2 set opens the lock, and protect bit 0 then reads 0.
- R10: Writes to start and limit are ignored while mode bit 0 (module enable) is 0.
- R11: The count moves only while mode bit 0 and quadrature-control bit 0 are both 1.
- R12: With a prescaler of 1, a phase change made between clock edges shows in the count after the third rising edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |

## Verification
The assertions check the register rules on every cycle. They confirm that start stays put when the lock is shut or the module is disabled, that a count write loads start, that the lock opens after an unlock write, that both wrap directions land on the right bound, that an up step adds exactly one, that up and down steps never coincide, and that the count holds while counting is disabled. Several behaviours can only be shown by the bench's scenarios, because they depend on the encoder's phase history and on time. These are the full X4 walk through legal and illegal transitions, the two-stage synchroniser latency, and the delayed first sample after a prescaler write.

// File: rtl/qpt_pkg.sv
package qpt_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] A_START = 3'd2;
    localparam logic [ADDR_W-1:0] A_LIMIT = 3'd3;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd4;
    localparam logic [ADDR_W-1:0] A_PROT  = 3'd5;
    localparam logic [ADDR_W-1:0] A_QCTL  = 3'd6;

    localparam int MODE_EN_BIT     = 0;
    localparam int MODE_UNLOCK_BIT = 2;
    localparam int PROT_LOCK_BIT   = 0;
    localparam int QCTL_EN_BIT     = 0;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_SHUT = 1'b1
    } lock_state_t;

    // encoding is the sampled {A,B} pair
    typedef enum logic [1:0] {
        QP_00 = 2'b00,
        QP_01 = 2'b01,
        QP_10 = 2'b10,
        QP_11 = 2'b11
    } qphase_t;
endpackage

// File: rtl/qpt_sync.sv
module qpt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qpt_prescaler.sv
module qpt_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] mask;

    always_comb begin
        span = '0;
        span[ps] = 1'b1;
        mask = span[DIV_W-1:0] - {{(DIV_W-1){1'b0}}, 1'b1};
        tick = (div_q == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     div_q <= '0;
        else if (clear) div_q <= '0;
        else if (tick)  div_q <= '0;
        else            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/qpt_decoder.sv
module qpt_decoder
    import qpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic a_s,
    input  logic b_s,
    output logic step_up,
    output logic step_dn
);
    qphase_t state_q;
    qphase_t sample;
    logic    up_move;
    logic    dn_move;

    assign sample = qphase_t'({a_s, b_s});

    // state register: follows every sampled pair, legal or not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state_q <= QP_00;
        else if (tick) state_q <= sample;
    end

    // outputs: classify the transition
    always_comb begin
        up_move = 1'b0;
        dn_move = 1'b0;
        unique case (state_q)
            QP_00: begin
                up_move = (sample == QP_10);
                dn_move = (sample == QP_01);
            end
            QP_10: begin
                up_move = (sample == QP_11);
                dn_move = (sample == QP_00);
            end
            QP_11: begin
                up_move = (sample == QP_01);
                dn_move = (sample == QP_10);
            end
            QP_01: begin
                up_move = (sample == QP_00);
                dn_move = (sample == QP_11);
            end
            default: begin
                up_move = 1'b0;
                dn_move = 1'b0;
            end
        endcase
        step_up = tick & up_move;
        step_dn = tick & dn_move;
    end
endmodule

// File: rtl/qpt_position.sv
module qpt_position #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             up,
    input  logic             dn,
    input  logic             reload,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (reload) begin
            count <= start;
        end else if (run && up) begin
            count <= (count == limit) ? start : count + 1'b1;
        end else if (run && dn) begin
            count <= (count == start) ? limit : count - 1'b1;
        end
    end
endmodule

// File: rtl/qpt_regs.sv
module qpt_regs
    import qpt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  count,
    output logic [PS_W-1:0]   ps,
    output logic              ps_wr,
    output logic              cnt_wr,
    output logic              mod_en,
    output logic              qd_en,
    output logic [CNT_W-1:0]  start,
    output logic [CNT_W-1:0]  limit,
    output logic              locked
);
    lock_state_t lk_q, lk_d;
    logic        wr_ok;

    // lock state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_OPEN;
        else        lk_q <= lk_d;
    end

    // lock next state and outputs
    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_OPEN: if (we && addr == A_PROT && wdata[PROT_LOCK_BIT]) lk_d = LK_SHUT;
            LK_SHUT: if (we && addr == A_MODE && wdata[MODE_UNLOCK_BIT]) lk_d = LK_OPEN;
            default: lk_d = LK_OPEN;
        endcase
        locked = (lk_q == LK_SHUT);
        wr_ok  = we && (lk_q == LK_OPEN);
        ps_wr  = wr_ok && addr == A_CTRL;
        cnt_wr = we && addr == A_COUNT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps     <= '0;
            mod_en <= 1'b0;
            qd_en  <= 1'b0;
            start  <= '0;
            limit  <= '0;
        end else if (wr_ok) begin
            unique case (addr)
                A_CTRL:  ps     <= wdata[PS_W-1:0];
                A_MODE:  mod_en <= wdata[MODE_EN_BIT];
                A_QCTL:  qd_en  <= wdata[QCTL_EN_BIT];
                A_START: if (mod_en) start <= wdata[CNT_W-1:0];
                A_LIMIT: if (mod_en) limit <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:  rdata[PS_W-1:0]        = ps;
            A_COUNT: rdata[CNT_W-1:0]       = count;
            A_START: rdata[CNT_W-1:0]       = start;
            A_LIMIT: rdata[CNT_W-1:0]       = limit;
            A_MODE:  rdata[MODE_EN_BIT]     = mod_en;
            A_PROT:  rdata[PROT_LOCK_BIT]   = locked;
            A_QCTL:  rdata[QCTL_EN_BIT]     = qd_en;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/quad_pos_timer.sv
module quad_pos_timer
    import qpt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              phase_a,
    input  logic              phase_b
);
    logic [1:0]       phase_s;
    logic             tick;
    logic             step_up;
    logic             step_dn;
    logic [PS_W-1:0]  ps;
    logic             ps_wr;
    logic             cnt_wr;
    logic             mod_en;
    logic             qd_en;
    logic             run;
    logic             locked;
    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;

    assign run = mod_en & qd_en;

    qpt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({phase_a, phase_b}),
        .dout (phase_s)
    );

    qpt_prescaler #(.PS_W(PS_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(ps_wr),
        .ps   (ps),
        .tick (tick)
    );

    qpt_decoder u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .a_s    (phase_s[1]),
        .b_s    (phase_s[0]),
        .step_up(step_up),
        .step_dn(step_dn)
    );

    qpt_position #(.CNT_W(CNT_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .up    (step_up),
        .dn    (step_dn),
        .reload(cnt_wr),
        .start (start),
        .limit (limit),
        .count (count)
    );

    qpt_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .count (count),
        .ps    (ps),
        .ps_wr (ps_wr),
        .cnt_wr(cnt_wr),
        .mod_en(mod_en),
        .qd_en (qd_en),
        .start (start),
        .limit (limit),
        .locked(locked)
    );
endmodule

// File: rtl/qpt_checker.sv
module qpt_checker
    import qpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              unlock_bit,
    input logic              lock_q,
    input logic              mod_en,
    input logic              run,
    input logic              step_up,
    input logic              step_dn,
    input logic [CNT_W-1:0]  start_q,
    input logic [CNT_W-1:0]  limit_q,
    input logic [CNT_W-1:0]  count_q
);
    logic cnt_write;
    logic start_write;
    assign cnt_write   = bus_we && bus_addr == A_COUNT;
    assign start_write = bus_we && bus_addr == A_START;

    // R8
    locked_start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q && start_write |=> $stable(start_q));

    // R10
    disabled_start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en && start_write |=> $stable(start_q));

    // R6
    count_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_write |=> count_q == $past(start_q));

    // R9
    unlock_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr == A_MODE && unlock_bit |=> !lock_q);

    // R4
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && step_up && !cnt_write && count_q == limit_q |=> count_q == $past(start_q));

    // R5
    wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && step_dn && !cnt_write && count_q == start_q |=> count_q == $past(limit_q));

    // R2
    step_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && step_up && !cnt_write && count_q != limit_q |=> count_q == $past(count_q) + 1'b1);

    // R3
    step_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !cnt_write |=> $stable(count_q));
endmodule

bind quad_pos_timer qpt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .unlock_bit(bus_wdata[qpt_pkg::MODE_UNLOCK_BIT]),
    .lock_q    (locked),
    .mod_en    (mod_en),
    .run       (run),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .start_q   (start),
    .limit_q   (limit),
    .count_q   (count)
);

// File: tb/quad_pos_timer_test.sv
`timescale 1ns/1ps
module quad_pos_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    int          checks = 0;
    int          errors = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    quad_pos_timer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .phase_a  (phase_a),
        .phase_b  (phase_b)
    );

    // {A, B, expected count}: start 0, limit 0xFFFF
    localparam logic [17:0] VEC [12] = '{
        {2'b10, 16'h0001}, {2'b11, 16'h0002}, {2'b01, 16'h0003}, {2'b00, 16'h0004},
        {2'b01, 16'h0003}, {2'b00, 16'h0004}, {2'b11, 16'h0004}, {2'b10, 16'h0003},
        {2'b00, 16'h0002}, {2'b01, 16'h0001}, {2'b11, 16'h0000}, {2'b10, 16'hFFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [1:0] next_up(input logic [1:0] ab);
        case (ab)
            2'b00: return 2'b10;
            2'b10: return 2'b11;
            2'b11: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [1:0] next_dn(input logic [1:0] ab);
        case (ab)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic step(input logic up);
        logic [1:0] nx;
        nx = up ? next_up({phase_a, phase_b}) : next_dn({phase_a, phase_b});
        @(negedge clk);
        {phase_a, phase_b} = nx;
        repeat (5) @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, 32'd0);
        end

        wr(3'd4, 32'h1);
        wr(3'd3, 32'hFFFF);
        wr(3'd6, 32'h1);

        // R2 / R3 X4 walk including an illegal move
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            {phase_a, phase_b} = VEC[i][17:16];
            repeat (5) @(negedge clk);
            rd(3'd1, v);
            check(VEC[i][17:16] == 2'b11 && i == 6 ? "R3 illegal move" : "R2 x4 step", v, {16'd0, VEC[i][15:0]});
        end

        // R6 count write reloads start
        wr(3'd2, 32'h20);
        wr(3'd1, 32'h1234);
        rd(3'd1, v);
        check("R6 count reload", v, 32'h20);

        // R4 wrap up
        wr(3'd3, 32'h22);
        step(1'b1); rd(3'd1, v); check("R4 up step", v, 32'h21);
        step(1'b1); rd(3'd1, v); check("R4 up step", v, 32'h22);
        step(1'b1); rd(3'd1, v); check("R4 wrap to start", v, 32'h20);

        // R5 wrap down
        step(1'b0); rd(3'd1, v); check("R5 wrap to limit", v, 32'h22);

        // R11 quadrature disabled
        wr(3'd6, 32'h0);
        step(1'b1); rd(3'd1, v); check("R11 qctl off holds", v, 32'h22);
        wr(3'd6, 32'h1);
        rd(3'd1, v); check("R11 re-enable no jump", v, 32'h22);

        // R12 synchroniser latency
        @(negedge clk);
        {phase_a, phase_b} = next_up({phase_a, phase_b});
        @(negedge clk);
        @(negedge clk);
        rd(3'd1, v); check("R12 not after second edge", v, 32'h22);
        @(negedge clk);
        rd(3'd1, v); check("R12 after third edge", v, 32'h20);

        // R7 prescaler of 8, first sample 8 clocks after the write
        wr(3'd0, 32'h3);
        {phase_a, phase_b} = next_up({phase_a, phase_b});
        repeat (4) @(negedge clk);
        rd(3'd1, v); check("R7 before first sample", v, 32'h20);
        repeat (16) @(negedge clk);
        rd(3'd1, v); check("R7 after first sample", v, 32'h21);
        rd(3'd0, v); check("R7 control readback", v, 32'h3);
        wr(3'd0, 32'h0);

        // R8 lock
        wr(3'd5, 32'h1);
        rd(3'd5, v); check("R8 lock readback", v, 32'h1);
        wr(3'd2, 32'h55);
        rd(3'd2, v); check("R8 start locked", v, 32'h20);
        wr(3'd6, 32'h0);
        rd(3'd6, v); check("R8 qctl locked", v, 32'h1);
        wr(3'd0, 32'h5);
        rd(3'd0, v); check("R8 control locked", v, 32'h0);

        // R9 unlock
        wr(3'd4, 32'h5);
        rd(3'd5, v); check("R9 lock cleared", v, 32'h0);
        wr(3'd2, 32'h30);
        rd(3'd2, v); check("R9 start writable", v, 32'h30);

        // R10 module enable gates start and limit
        wr(3'd4, 32'h0);
        wr(3'd2, 32'h40);
        rd(3'd2, v); check("R10 start gated", v, 32'h30);
        wr(3'd3, 32'h99);
        rd(3'd3, v); check("R10 limit gated", v, 32'h22);

        // R11 module disabled stops counting
        step(1'b1); rd(3'd1, v); check("R11 mode off holds", v, 32'h21);

        done = 1'b1;
        summary();
    end
endmodule